// File: doc/BRIEF.md
# Serial Register Readback Unit

This unit answers serial read frames for a bank of four 10-bit channel registers. The chip-select, serial clock and serial data input are sampled by a faster system clock through a synchronizer, and serial clock edges are found by comparing successive synchronized samples. The unit takes the stored register values as a flat input bus, and it drives one serial data-out line plus an enable for the tri-state pad.

A frame opens when chip-select goes low. The first seven bits sampled on rising serial clock edges form a read instruction. That instruction picks one channel or all channels, picks the serial clock edge on which data is launched, and picks the bit order. When the instruction completes, the selected value is copied into a private shift register. After a fixed gap that depends on the launch edge, the bits are sent out one per selected edge. The line then holds its last bit until chip-select returns high, and this forces the pad back to high impedance at once.

Top module: `serial_readback_unit`

## Requirements
- R1: The instruction is the first 7 bits sampled on rising serial clock edges, sent first to last as: start (must be 1), direction (must be 1 for read), all-channels flag, launch edge (1 = rising), order (1 = MSB first), address bit 1, address bit 0. A frame whose start or direction bit is 0 never enables the output.
- R2: With launch edge 0, the first data bit and the enable appear on the falling serial clock edge that follows the 8th rising edge, and each later bit appears on the next falling edge.
- R3: With launch edge 1, the first data bit and the enable appear on the 9th rising serial clock edge, and each later bit appears on the next rising edge.
- R4: With order 1 each 10-bit word is sent from bit 9 down to bit 0; with order 0 it is sent from bit 0 up to bit 9.
- R5: A single-channel read sends exactly the 10 bits of the channel whose address is the 2-bit field; address 0 is the channel held in `chan_words_i[9:0]`, and channel k sits in `chan_words_i[10k+9:10k]`.
- R6: When the all-channels flag is 1, 40 bits are sent: channel 0 first, then 1, 2 and 3, each in the selected order. The address field is ignored.
- R7: After the last bit, the data line keeps its final value and the enable stays high while chip-select stays low, even if more serial clocks arrive.
- R8: Chip-select high clears the enable and the data line, whatever the transfer state. This holds even when it arrives together with a launch edge.
- R9: The register value is captured at the end of the instruction, so changes on `chan_words_i` during the transfer do not change the bits sent.
- R10: Outputs are registered, and they change only on a detected serial clock edge of the selected polarity or on chip-select high. An input change that the system clock samples reaches the outputs after SYNC_STAGES more clock edges.
- R11: After reset the enable and the data line are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Chip-select, active low, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| sdi_i | input | 1 | Serial data input carrying the instruction |
| chan_words_i | input | NUM_CH*WORD_W | Stored channel values, channel k at bits [k*WORD_W +: WORD_W] |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable for the tri-state pad |

## Verification
The delicate case is a chip-select release that reaches the synchronizer in the same system clock cycle as a serial clock edge that would otherwise launch the next bit. The bench provokes it in the middle of an all-channels transfer in falling-edge mode: it drives the serial clock low and chip-select high at the same instant, so both changes cross the synchronizer together. A behavioural model is compared on every system clock. In that model deselection outranks the launch, so the enable must drop and no further bit may appear. A normal frame that follows must then read back correctly.

// File: rtl/serial_readback_pkg.sv
package serial_readback_pkg;

   // serial clock edge on which read data is launched
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } launch_edge_e;

   // instruction bits ahead of the address field: start, direction, all, edge, order
   localparam int unsigned HDR_BITS = 5;

   // bit order of the synchronized serial bus
   localparam int unsigned SB_SEL  = 2;
   localparam int unsigned SB_SCLK = 1;
   localparam int unsigned SB_SDI  = 0;

endpackage

// File: rtl/rb_sync_bus.sv
module rb_sync_bus #(
   parameter int unsigned N       = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);

   generate
      if (STAGES == 1) begin : g_single
         logic [N-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d_i;
         end
         assign q_o = r;
      end else begin : g_chain
         logic [N-1:0] r [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) r[s] <= RST_VAL;
            end else begin
               r[0] <= d_i;
               for (int s = 1; s < STAGES; s++) r[s] <= r[s-1];
            end
         end
         assign q_o = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rb_instr_decode.sv
module rb_instr_decode
   import serial_readback_pkg::*;
#(
   parameter int unsigned AW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idle_i,
   input  logic          rise_i,
   input  logic          sdi_i,
   output logic          load_o,
   output logic          glob_o,
   output logic          msb_o,
   output logic [AW-1:0] addr_o,
   output logic          armed_o,
   output launch_edge_e  edge_sel_o
);

   localparam int unsigned INS_LEN = HDR_BITS + AW;
   localparam int unsigned CW      = $clog2(INS_LEN + 2);
   localparam int unsigned P_START = INS_LEN - 1;
   localparam int unsigned P_DIR   = INS_LEN - 2;
   localparam int unsigned P_GLOB  = INS_LEN - 3;
   localparam int unsigned P_EDGE  = INS_LEN - 4;
   localparam int unsigned P_ORD   = INS_LEN - 5;
   localparam logic [CW-1:0] CNT_LAST = CW'(INS_LEN - 1);
   localparam logic [CW-1:0] CNT_ARM  = CW'(INS_LEN + 1);

   logic [CW-1:0]      cnt_q;
   logic [INS_LEN-2:0] ins_q;
   logic               ok_q;
   launch_edge_e       edge_q;
   logic [INS_LEN-1:0] full;

   assign full   = {ins_q, sdi_i};
   assign load_o = rise_i && !idle_i && (cnt_q == CNT_LAST)
                   && full[P_START] && full[P_DIR];
   assign glob_o = full[P_GLOB];
   assign msb_o  = full[P_ORD];
   assign addr_o = full[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ins_q  <= '0;
         ok_q   <= 1'b0;
         edge_q <= EDGE_FALL;
      end else if (idle_i) begin
         cnt_q <= '0;
         ok_q  <= 1'b0;
      end else if (rise_i && (cnt_q != CNT_ARM)) begin
         cnt_q <= cnt_q + 1'b1;
         ins_q <= full[INS_LEN-2:0];
         if (load_o) begin
            ok_q   <= 1'b1;
            edge_q <= launch_edge_e'(full[P_EDGE]);
         end
      end
   end

   assign armed_o    = ok_q && (cnt_q == CNT_ARM);
   assign edge_sel_o = edge_q;

endmodule

// File: rtl/rb_serializer.sv
module rb_serializer #(
   parameter int unsigned NCH = 4,
   parameter int unsigned W   = 10,
   parameter int unsigned AW  = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           idle_i,
   input  logic           load_i,
   input  logic           glob_i,
   input  logic           msb_i,
   input  logic [AW-1:0]  addr_i,
   input  logic [NCH*W-1:0] words_i,
   input  logic           launch_i,
   output logic           sdo_o,
   output logic           oe_o
);

   localparam int unsigned TOT = NCH * W;
   localparam int unsigned LW  = $clog2(TOT + 1);

   logic [W-1:0]   fwd [NCH];
   logic [W-1:0]   rev [NCH];
   logic [TOT-1:0] img;
   logic [TOT-1:0] sh_q;
   logic [LW-1:0]  left_q;
   logic           fire;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         assign fwd[c] = words_i[c*W +: W];
         for (genvar b = 0; b < W; b++) begin : g_bit
            assign rev[c][b] = words_i[c*W + (W-1-b)];
         end
      end
   endgenerate

   // channel 0 sits at the top of the chain and leaves first
   always_comb begin
      img = '0;
      if (glob_i) begin
         for (int c = 0; c < NCH; c++)
            img[(NCH-1-c)*W +: W] = msb_i ? fwd[c] : rev[c];
      end else begin
         img[TOT-1 -: W] = msb_i ? fwd[addr_i] : rev[addr_i];
      end
   end

   assign fire = launch_i && (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
         sdo_o  <= 1'b0;
         oe_o   <= 1'b0;
      end else if (idle_i) begin
         left_q <= '0;
         sdo_o  <= 1'b0;
         oe_o   <= 1'b0;
      end else if (load_i) begin
         sh_q   <= img;
         left_q <= glob_i ? LW'(TOT) : LW'(W);
      end else if (fire) begin
         sdo_o  <= sh_q[TOT-1];
         sh_q   <= sh_q << 1;
         left_q <= left_q - 1'b1;
         oe_o   <= 1'b1;
      end
   end

endmodule

// File: rtl/serial_readback_unit.sv
module serial_readback_unit
   import serial_readback_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned WORD_W      = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sel_n_i,
   input  logic                     sclk_i,
   input  logic                     sdi_i,
   input  logic [NUM_CH*WORD_W-1:0] chan_words_i,
   output logic                     sdo_o,
   output logic                     sdo_oe_o
);

   localparam int unsigned AW = $clog2(NUM_CH);

   generate
      if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
         $error("NUM_CH must be a power of two of at least 2");
      end
      if (WORD_W < 1) begin : g_bad_w
         $error("WORD_W must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [2:0]   sync_lvl;
   logic         idle;
   logic         sclk_prev;
   logic         s_rise;
   logic         s_fall;
   logic         load;
   logic         glob;
   logic         msb;
   logic [AW-1:0] addr;
   logic         armed;
   launch_edge_e edge_sel;
   logic         edge_rise;
   logic         launch;

   rb_sync_bus #(
      .N       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sel_n_i, sclk_i, sdi_i}),
      .q_o   (sync_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sync_lvl[SB_SCLK];
   end

   assign idle   = sync_lvl[SB_SEL];
   assign s_rise = sync_lvl[SB_SCLK] && !sclk_prev;
   assign s_fall = !sync_lvl[SB_SCLK] && sclk_prev;

   rb_instr_decode #(.AW(AW)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .idle_i     (idle),
      .rise_i     (s_rise),
      .sdi_i      (sync_lvl[SB_SDI]),
      .load_o     (load),
      .glob_o     (glob),
      .msb_o      (msb),
      .addr_o     (addr),
      .armed_o    (armed),
      .edge_sel_o (edge_sel)
   );

   assign edge_rise = (edge_sel == EDGE_RISE);
   assign launch    = armed && (edge_rise ? s_rise : s_fall);

   rb_serializer #(.NCH(NUM_CH), .W(WORD_W), .AW(AW)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle_i   (idle),
      .load_i   (load),
      .glob_i   (glob),
      .msb_i    (msb),
      .addr_i   (addr),
      .words_i  (chan_words_i),
      .launch_i (launch),
      .sdo_o    (sdo_o),
      .oe_o     (sdo_oe_o)
   );

endmodule

// File: rtl/rb_readback_chk.sv
module rb_readback_chk (
   input logic clk,
   input logic rst_n,
   input logic idle,
   input logic s_rise,
   input logic s_fall,
   input logic edge_rise,
   input logic sdo,
   input logic sdo_oe
);

   AST_OFF_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> (!sdo_oe && !sdo)); // R8

   AST_QUIET_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !s_rise && !s_fall) |=> ($stable(sdo) && $stable(sdo_oe))); // R10

   AST_FALL_MODE_START: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sdo_oe) && !edge_rise) |-> $past(s_fall)); // R2

   AST_RISE_MODE_START: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sdo_oe) && edge_rise) |-> $past(s_rise)); // R3

   AST_ENABLE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> $past(!idle)); // R8

endmodule

bind serial_readback_unit rb_readback_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .idle      (idle),
   .s_rise    (s_rise),
   .s_fall    (s_fall),
   .edge_rise (edge_rise),
   .sdo       (sdo_o),
   .sdo_oe    (sdo_oe_o)
);

// File: tb/serial_readback_unit_test.sv
module serial_readback_unit_test;

   localparam int NCH = 4;
   localparam int W   = 10;
   localparam int SYN = 2;
   localparam int HP  = 6;
   localparam int TOT = NCH * W;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sel_n = 1'b1;
   logic           sclk = 1'b0;
   logic           sdi = 1'b0;
   logic [TOT-1:0] words;
   logic           sdo;
   logic           oe;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   string tag = "R11";

   always #4 clk = ~clk;

   serial_readback_unit #(.NUM_CH(NCH), .WORD_W(W), .SYNC_STAGES(SYN)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_n_i      (sel_n),
      .sclk_i       (sclk),
      .sdi_i        (sdi),
      .chan_words_i (words),
      .sdo_o        (sdo),
      .sdo_oe_o     (oe)
   );

   task automatic chk(input bit ok, input string req, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model (R10 latency) ----------------
   logic [2:0] hist [0:SYN+1];
   int   m_cnt;
   bit   m_ok, m_rise, e_oe, e_sdo;
   bit [6:0] m_ins;
   bit   m_bits[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i <= SYN+1; i++) hist[i] = 3'b100;
      end else begin
         for (int i = SYN+1; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = {sel_n, sclk, sdi};
      end
   end

   always @(negedge clk) begin
      logic [2:0] nw, od;
      bit r, f;
      nw = hist[SYN];
      od = hist[SYN+1];
      if (!rst_n || nw[2]) begin
         e_oe = 0; e_sdo = 0; m_cnt = 0; m_ok = 0; m_bits.delete();
      end else begin
         r = nw[1] && !od[1];
         f = !nw[1] && od[1];
         if (m_ok && m_cnt >= 8 && (m_rise ? r : f) && m_bits.size() > 0) begin
            e_sdo = m_bits.pop_front();
            e_oe  = 1;
         end
         if (r && m_cnt < 8) begin
            m_ins = {m_ins[5:0], nw[0]};
            m_cnt++;
            if (m_cnt == 7 && m_ins[6] && m_ins[5]) begin
               m_ok = 1;
               m_rise = m_ins[3];
               for (int c = 0; c < NCH; c++) begin
                  if (m_ins[4] || c == int'(m_ins[1:0])) begin
                     for (int i = 0; i < W; i++)
                        m_bits.push_back(m_ins[2] ? words[c*W + W-1-i] : words[c*W + i]);
                  end
               end
            end
         end
      end
      if (rst_n) begin
         checks++;
         if (oe !== e_oe || sdo !== e_sdo) begin
            failures++;
            $display("FAIL R10 (%s) cycle %0d actual oe=%b sdo=%b expected oe=%b sdo=%b",
                     tag, cyc, oe, sdo, e_oe, e_sdo);
         end
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         failures++;
         $display("FAIL R10 watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------------- serial master ----------------
   task automatic ser_cycle(input bit din, output bit b_lo, output bit b_hi, output bit o_lo, output bit o_hi);
      sclk = 0; sdi = din;
      repeat (HP) @(negedge clk);
      b_lo = sdo; o_lo = oe;
      sclk = 1;
      repeat (HP) @(negedge clk);
      b_hi = sdo; o_hi = oe;
   endtask

   function automatic logic [TOT-1:0] expect_vec(input bit glob, input bit msb, input int addr, input int n);
      logic [TOT-1:0] v = '0;
      for (int k = 0; k < n; k++) begin
         int ch = glob ? k / W : addr;
         int i  = k % W;
         v[k] = msb ? words[ch*W + W-1-i] : words[ch*W + i];
      end
      return v;
   endfunction

   task automatic run_frame(input bit [6:0] ins, input int n, input int mutate_at,
                            output logic [TOT-1:0] got, output bit oe_ok, output bit early_oe,
                            output bit hold_ok, output bit any_oe);
      bit lo, hi, ol, oh;
      bit rising = ins[3];
      got = '0; oe_ok = 1; early_oe = 0; hold_ok = 1; any_oe = 0;
      sel_n = 0; sclk = 0;
      repeat (HP) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         ser_cycle(i < 7 ? ins[6-i] : 1'b0, lo, hi, ol, oh);
         early_oe |= ol | oh;
      end
      for (int k = 0; k < n; k++) begin
         if (k == mutate_at) words = ~words;
         ser_cycle(1'b0, lo, hi, ol, oh);
         got[k] = rising ? hi : lo;
         oe_ok &= rising ? oh : ol;
         any_oe |= ol | oh;
      end
      for (int k = 0; k < 2; k++) begin
         ser_cycle(1'b0, lo, hi, ol, oh);
         hold_ok &= (lo == got[n-1]) && (hi == got[n-1]) && ol && oh;
      end
      sclk = 0;
      repeat (HP) @(negedge clk);
      sel_n = 1;
      repeat (2*HP) @(negedge clk);
   endtask

   task automatic read_test(input string req, input bit glob, input bit rf, input bit msb,
                            input int addr, input int mutate_at);
      logic [TOT-1:0] got, exp;
      bit oe_ok, early, hold_ok, any;
      int n = glob ? TOT : W;
      tag = req;
      exp = expect_vec(glob, msb, addr, n);
      run_frame({1'b1, 1'b1, glob, rf, msb, 2'(addr)}, n, mutate_at, got, oe_ok, early, hold_ok, any);
      chk(got == exp, req, got, exp);
      chk(oe_ok && !early, rf ? "R3 enable timing" : "R2 enable timing",
          TOT'({oe_ok, early}), TOT'(2'b10));
      chk(hold_ok, "R7 hold after last bit", TOT'(hold_ok), TOT'(1));
      chk(oe === 1'b0, "R8 enable off after deselect", TOT'(oe), '0);
   endtask

   initial begin
      bit lo, hi, ol, oh;
      logic [TOT-1:0] got;
      bit oe_ok, early, hold_ok, any;
      words = {10'h00F, 10'h3F0, 10'h13C, 10'h2A5};
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11: reset state
      chk(oe === 1'b0 && sdo === 1'b0, "R11 reset outputs", TOT'({oe, sdo}), '0);
      repeat (4) @(negedge clk);

      // R2 R4 R5: single, falling edge, MSB first, channel 2
      read_test("R5 single fall msb ch2", 0, 0, 1, 2, -1);
      // R3 R4 R5: single, rising edge, LSB first, channel 0
      read_test("R4 single rise lsb ch0", 0, 1, 0, 0, -1);
      // R6: all channels, falling edge, LSB first, address field ignored (3)
      read_test("R6 global fall lsb", 1, 0, 0, 3, -1);
      // R6 R3: all channels, rising edge, MSB first
      read_test("R6 global rise msb", 1, 1, 1, 0, -1);
      // R9: register changes mid-transfer
      read_test("R9 capture isolation ch1", 0, 0, 1, 1, 4);
      words = {10'h155, 10'h2AA, 10'h301, 10'h0C3};

      // R1: start bit 0 and direction bit 0 frames never enable
      tag = "R1";
      run_frame(7'b0110100, W, -1, got, oe_ok, early, hold_ok, any);
      chk(!any && !early, "R1 start bit zero ignored", TOT'(any), '0);
      run_frame(7'b1000100, W, -1, got, oe_ok, early, hold_ok, any);
      chk(!any && !early, "R1 write frame ignored", TOT'(any), '0);

      // R8: deselect arrives together with a launch (falling) edge mid-transfer
      tag = "R8 collision";
      sel_n = 0; sclk = 0;
      repeat (HP) @(negedge clk);
      for (int i = 0; i < 13; i++) begin
         bit [6:0] ins = 7'b1110100;
         ser_cycle(i < 7 ? ins[6-i] : 1'b0, lo, hi, ol, oh);
      end
      chk(oe === 1'b1, "R8 enable before collision", TOT'(oe), TOT'(1));
      sclk = 0; sel_n = 1;
      repeat (HP) @(negedge clk);
      chk(oe === 1'b0 && sdo === 1'b0, "R8 collision clears outputs", TOT'({oe, sdo}), '0);
      repeat (HP) @(negedge clk);

      // recovery after abort
      read_test("R5 single rise msb ch3", 0, 1, 1, 3, -1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule